// File: doc/BRIEF.md
# Dual Frame Buffer Fetch Sequencer

This block reads pixel words for a raster display out of memory and loads them into a local pixel FIFO. Two frame buffers are described by a start word address and an inclusive end word address each. With alternation switched on, successive frames are fetched from buffer 0, then buffer 1, then buffer 0 again. Software reprograms whichever buffer is idle while the other one is read. When a frame ends, a status flag for the buffer just finished is raised. Each flag can be routed to a single interrupt line.

Reads are issued as bursts on a simple request/grant port. The burst size comes from a 3-bit code. The last burst of a frame is trimmed so that it never passes the end address. A burst is requested only when the FIFO has room for the whole of it. A one-shot palette mode reads the buffer 0 range a single time, raises a palette-done flag and then waits for the run input to fall. Addresses are word addresses, and the start address must not exceed the end address.

Top module: `fbdma_seq`

## Requirements
- R1: After a synchronous reset, `mem_req`, `status`, `irq`, `pix_avail` and `pix_valid` are all 0.
- R2: `burst_code` values 0, 1, 2, 3 and 4 give bursts of 1, 2, 4, 8 and 16 words. Bursts walk upward from the start address, each one beginning at the word after the previous burst. `mem_addr` and `mem_len` hold steady while `mem_req` waits for `mem_gnt`.
- R3: A burst never reaches past the end address. The final burst of a frame carries only the words that remain.
- R4: `burst_code` values 5, 6 and 7 are treated as single-word bursts.
- R5: With `dual_en`=1, frames alternate between buffer 0 and buffer 1, starting with buffer 0 after reset. With `dual_en`=0, every frame reads buffer 0.
- R6: Finishing a frame of buffer 0 sets `status[8]`, and finishing a frame of buffer 1 sets `status[9]`. Each flag is visible two clock edges after the edge that accepts the frame's last word.
- R7: Writing 1 on a `stat_clr` bit clears the matching `status` bit on the next edge. Other status bits are left as they are. A set and a clear arriving in the same cycle leave the bit set.
- R8: Start and end addresses are captured when a frame starts. Changing them during a frame has no effect until that buffer's next frame.
- R9: With `load_mode`=1 (palette only), the buffer 0 range is read once regardless of `dual_en`. `status[6]` is then set, neither end-of-frame flag is set, and no request is made until `run` falls. The other `load_mode` codes (0, 2, 3) fetch frames continuously while `run` is high.
- R10: No burst is requested while the FIFO has fewer free entries than the burst length. Fetching resumes once enough entries have been popped.
- R11: Popping while the FIFO is empty sets `status[5]` on the next edge and produces no `pix_valid`.
- R12: `irq` is 1 one edge after any status bit whose `irq_en` bit is set is 1, and 0 otherwise.
- R13: Words come out of `pix_data` in the order they were received, unchanged. Each one appears one edge after its pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start a frame whenever idle and high |
| dual_en | input | 1 | Alternate between the two buffers |
| burst_code | input | 3 | Encoded burst length |
| load_mode | input | 2 | 1 = palette only, else frame data |
| base0 | input | AW | Buffer 0 start word address |
| ceil0 | input | AW | Buffer 0 inclusive end address |
| base1 | input | AW | Buffer 1 start word address |
| ceil1 | input | AW | Buffer 1 inclusive end address |
| mem_req | output | 1 | Burst request |
| mem_addr | output | AW | Burst start address |
| mem_len | output | 5 | Burst length in words |
| mem_gnt | input | 1 | Request accepted |
| rd_valid | input | 1 | Read word present |
| rd_data | input | DW | Read word |
| pix_pop | input | 1 | Consumer takes a word |
| pix_data | output | DW | Popped word |
| pix_valid | output | 1 | pix_data holds a popped word |
| pix_avail | output | 1 | FIFO is not empty |
| stat_clr | input | 10 | Write-1-to-clear strobes |
| irq_en | input | 10 | Interrupt enable per status bit |
| status | output | 10 | Bits 9, 8, 6 and 5 are flags, the rest read 0 |
| irq | output | 1 | Interrupt |

## Verification
Every expectation is tied to a fixed edge count. A new burst request shows up two edges after the last word of the previous burst. An end-of-frame or palette flag appears two edges after the final accepted word. `irq` follows one edge after the flag, a clear takes effect one edge after its strobe, and popped data arrives one edge after the pop. The bench drives inputs on the falling edge and samples at the falling edge where each result is due. Burst address and length are compared against values it computes itself from the start address, end address and burst size. The no-request window under a full FIFO and after palette completion is checked across many consecutive cycles.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;
  localparam int MAX_BURST = 16;
  localparam int LENW      = $clog2(MAX_BURST) + 1;
  localparam int STW       = 10;
  localparam int BIT_UFLOW = 5;
  localparam int BIT_PLDN  = 6;
  localparam int BIT_EOF0  = 8;
  localparam int BIT_EOF1  = 9;
  localparam logic [1:0] MODE_PAL_ONLY = 2'd1;

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_REQ, S_DATA, S_HALT} seq_state_t;

  function automatic logic [LENW-1:0] burst_words(input logic [2:0] code);
    case (code)
      3'd0:    return LENW'(1);
      3'd1:    return LENW'(2);
      3'd2:    return LENW'(4);
      3'd3:    return LENW'(8);
      3'd4:    return LENW'(16);
      default: return LENW'(1);
    endcase
  endfunction
endpackage

// File: rtl/fbdma_fifo.sv
module fbdma_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          avail,
  output logic [CW-1:0] free_slots,
  output logic          uflow
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          rd_ok;

  assign avail      = (count != '0);
  assign rd_ok      = pop && avail;
  assign uflow      = pop && !avail;
  assign free_slots = CW'(DEPTH) - count;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
    if (rd_ok) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0; count <= '0; rvalid <= 1'b0;
    end else begin
      rvalid <= rd_ok;
      if (push)  wp <= wp + PW'(1);
      if (rd_ok) rp <= rp + PW'(1);
      case ({push, rd_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: ;
      endcase
    end
  end

  // R10: the sequencer never pushes into a full FIFO
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CW'(DEPTH)));
  // R11: an empty pop yields no data strobe
  p_empty_pop_r11: assert property (@(posedge clk) disable iff (rst)
    uflow |=> !rvalid);
endmodule

// File: rtl/fbdma_status.sv
module fbdma_status import fbdma_pkg::*; (
  input  logic           clk,
  input  logic           rst,
  input  logic [STW-1:0] set_vec,
  input  logic [STW-1:0] clr,
  input  logic [STW-1:0] irq_en,
  output logic [STW-1:0] status,
  output logic           irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr) | set_vec;
      irq    <= |(status & irq_en);
    end
  end

  // R7: a cleared bit with no simultaneous event reads 0 next cycle
  p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    ((clr & ~set_vec) != '0) |=> ((status & $past(clr & ~set_vec)) == '0));
  // R6: an event always lands in its flag
  p_set_r6: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/fbdma_ctrl.sv
module fbdma_ctrl import fbdma_pkg::*; #(
  parameter int AW = 16,
  parameter int CW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            dual_en,
  input  logic [2:0]      burst_code,
  input  logic [1:0]      load_mode,
  input  logic [AW-1:0]   base0,
  input  logic [AW-1:0]   ceil0,
  input  logic [AW-1:0]   base1,
  input  logic [AW-1:0]   ceil1,
  input  logic [CW-1:0]   free_slots,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  output logic [LENW-1:0] mem_len,
  input  logic            mem_gnt,
  input  logic            rd_valid,
  output logic            push,
  output logic            eof0_evt,
  output logic            eof1_evt,
  output logic            pl_evt
);
  seq_state_t      state;
  logic            cur_buf, pal_q, start_buf;
  logic [AW-1:0]   addr_q, ceil_q;
  logic [LENW-1:0] len_q, left_q, len_c;
  logic [AW:0]     rem_w, blen_w;

  always_comb begin
    start_buf = (load_mode == MODE_PAL_ONLY) ? 1'b0 : cur_buf;
    rem_w     = {1'b0, ceil_q} - {1'b0, addr_q} + (AW+1)'(1);
    blen_w    = (AW+1)'(burst_words(burst_code));
    len_c     = (rem_w < blen_w) ? rem_w[LENW-1:0] : blen_w[LENW-1:0];
  end

  assign mem_req  = (state == S_REQ);
  assign mem_addr = addr_q;
  assign mem_len  = len_q;
  assign push     = (state == S_DATA) && rd_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; cur_buf <= 1'b0; pal_q <= 1'b0;
      addr_q <= '0; ceil_q <= '0; len_q <= '0; left_q <= '0;
      eof0_evt <= 1'b0; eof1_evt <= 1'b0; pl_evt <= 1'b0;
    end else begin
      eof0_evt <= 1'b0; eof1_evt <= 1'b0; pl_evt <= 1'b0;
      case (state)
        S_IDLE: if (run) begin
          cur_buf <= start_buf;
          addr_q  <= start_buf ? base1 : base0;
          ceil_q  <= start_buf ? ceil1 : ceil0;
          pal_q   <= (load_mode == MODE_PAL_ONLY);
          state   <= S_CHK;
        end
        S_CHK: if (32'(free_slots) >= 32'(len_c)) begin
          len_q <= len_c;
          state <= S_REQ;
        end
        S_REQ: if (mem_gnt) begin
          left_q <= len_q;
          state  <= S_DATA;
        end
        S_DATA: if (rd_valid) begin
          addr_q <= addr_q + AW'(1);
          left_q <= left_q - LENW'(1);
          if (left_q == LENW'(1)) begin
            if (addr_q == ceil_q) begin
              if (pal_q) begin
                pl_evt  <= 1'b1;
                cur_buf <= 1'b0;
                state   <= S_HALT;
              end else begin
                eof0_evt <= !cur_buf;
                eof1_evt <= cur_buf;
                cur_buf  <= dual_en ? ~cur_buf : 1'b0;
                state    <= S_IDLE;
              end
            end else begin
              state <= S_CHK;
            end
          end
        end
        S_HALT: if (!run) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: a waiting request keeps address and length
  p_req_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)));
  // R2: burst length is within the legal range
  p_len_legal_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_len != '0 && mem_len <= LENW'(MAX_BURST)));
  // R3: no burst crosses the latched end address
  p_no_overrun_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (({1'b0, mem_addr} + (AW+1)'(mem_len) - (AW+1)'(1)) <= {1'b0, ceil_q}));
  // R10: a request is only raised with room for the whole burst
  p_room_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> (32'(free_slots) >= 32'(mem_len)));
  // R9: palette completion never raises an end-of-frame event
  p_pal_no_eof_r9: assert property (@(posedge clk) disable iff (rst)
    pl_evt |-> !(eof0_evt || eof1_evt));
endmodule

// File: rtl/fbdma_seq.sv
module fbdma_seq import fbdma_pkg::*; #(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int FIFO_DEPTH = 32,
  localparam int CW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            dual_en,
  input  logic [2:0]      burst_code,
  input  logic [1:0]      load_mode,
  input  logic [AW-1:0]   base0,
  input  logic [AW-1:0]   ceil0,
  input  logic [AW-1:0]   base1,
  input  logic [AW-1:0]   ceil1,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  output logic [LENW-1:0] mem_len,
  input  logic            mem_gnt,
  input  logic            rd_valid,
  input  logic [DW-1:0]   rd_data,
  input  logic            pix_pop,
  output logic [DW-1:0]   pix_data,
  output logic            pix_valid,
  output logic            pix_avail,
  input  logic [STW-1:0]  stat_clr,
  input  logic [STW-1:0]  irq_en,
  output logic [STW-1:0]  status,
  output logic            irq
);
  logic          push, uflow, eof0_evt, eof1_evt, pl_evt;
  logic [CW-1:0] free_slots;
  logic [STW-1:0] set_vec;

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_EOF0]  = eof0_evt;
    set_vec[BIT_EOF1]  = eof1_evt;
    set_vec[BIT_PLDN]  = pl_evt;
    set_vec[BIT_UFLOW] = uflow;
  end

  fbdma_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
    .clk, .rst, .run, .dual_en, .burst_code, .load_mode,
    .base0, .ceil0, .base1, .ceil1, .free_slots,
    .mem_req, .mem_addr, .mem_len, .mem_gnt, .rd_valid, .push,
    .eof0_evt, .eof1_evt, .pl_evt
  );

  fbdma_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst, .push, .wdata(rd_data), .pop(pix_pop),
    .rdata(pix_data), .rvalid(pix_valid), .avail(pix_avail),
    .free_slots, .uflow
  );

  fbdma_status u_stat (
    .clk, .rst, .set_vec, .clr(stat_clr), .irq_en, .status, .irq
  );
endmodule

// File: tb/sim_fbdma_seq.sv
module sim_fbdma_seq;
  localparam int CLK_NS = 10;

  logic clk = 0, rst = 1, run = 0, dual_en = 0;
  logic [2:0] burst_code = 0;
  logic [1:0] load_mode = 2;
  logic [15:0] base0 = 0, ceil0 = 0, base1 = 0, ceil1 = 0;
  logic mem_req, mem_gnt = 0, rd_valid = 0;
  logic [15:0] mem_addr;
  logic [4:0] mem_len;
  logic [31:0] rd_data = 0, pix_data;
  logic cons_pop = 0, force_pop = 0, drain_en = 1, pix_pop, pix_valid, pix_avail, irq;
  logic [9:0] stat_clr = 0, irq_en = 0, status;
  logic [31:0] expq[$];
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  assign pix_pop = cons_pop | force_pop;
  always #(CLK_NS/2) clk = ~clk;

  fbdma_seq u0 (.*);

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_req(output bit got);
    got = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (mem_req) begin got = 1; break; end
    end
  endtask

  task automatic serve_bursts(input int a0, input int ceil, input int blen, input int nb,
                              input string tag, output int anext);
    int a = a0;
    int n = 0;
    while (a <= ceil && n < nb) begin
      bit got;
      int exp_len, len_act;
      exp_len = (ceil - a + 1 < blen) ? ceil - a + 1 : blen;
      wait_req(got);
      if (!got) begin
        chk(0, {tag, " no request"}, 0, 1);
        anext = a;
        return;
      end
      chk(mem_addr == a, {tag, " burst address"}, mem_addr, a);
      chk(mem_len == exp_len, {tag, " burst length"}, mem_len, exp_len);
      len_act = (mem_len == 0) ? 1 : int'(mem_len);
      mem_gnt = 1;
      @(negedge clk);
      mem_gnt = 0;
      for (int k = 0; k < len_act; k++) begin
        rd_valid = 1;
        rd_data = 32'hD000_0000 | (a + k);
        expq.push_back(rd_data);
        @(negedge clk);
      end
      rd_valid = 0;
      a += len_act;
      n++;
    end
    anext = a;
  endtask

  task automatic serve_frame(input int a0, input int ceil, input int blen, input string tag);
    int an;
    serve_bursts(a0, ceil, blen, 1000, tag, an);
  endtask

  task automatic clr_stat(input logic [9:0] m);
    @(negedge clk); stat_clr = m;
    @(negedge clk); stat_clr = 0;
  endtask

  task automatic pulse_run();
    @(negedge clk); run = 1;
    @(negedge clk); run = 0;
  endtask

  task automatic drain(input string tag);
    drain_en = 1;
    repeat (60) @(negedge clk);
    chk(expq.size() == 0, {tag, " R13 all words delivered"}, expq.size(), 0);
  endtask

  task automatic do_reset();
    run = 0; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    expq.delete();
  endtask

  // consumer: checks popped words in arrival order (R13)
  initial begin
    forever begin
      @(negedge clk);
      if (pix_valid) begin
        if (expq.size() == 0) chk(0, "R13 unexpected word", pix_data, 0);
        else begin
          logic [31:0] e;
          e = expq.pop_front();
          chk(pix_data == e, "R13 word order/content", pix_data, e);
        end
      end
      cons_pop = drain_en && pix_avail && !rst;
    end
  end

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int an, hits;
    do_reset();
    @(negedge clk);
    chk(mem_req == 0, "R1 mem_req after reset", mem_req, 0);
    chk(status == 0, "R1 status after reset", status, 0);
    chk(irq == 0, "R1 irq after reset", irq, 0);
    chk(pix_avail == 0 && pix_valid == 0, "R1 fifo outputs after reset", pix_avail, 0);

    // R2 / R3: sweep legal burst codes over a 38-word frame
    for (int c = 0; c < 5; c++) begin
      do_reset();
      burst_code = c[2:0]; base0 = 10; ceil0 = 47; load_mode = 2;
      pulse_run();
      serve_frame(10, 47, 1 << c, "R2 R3 sweep");
      @(negedge clk);
      chk(status[8] == 1, "R6 eof0 after sweep frame", status[8], 1);
      drain("R2");
    end

    // R4: illegal codes act as single-word bursts
    for (int c = 5; c < 8; c++) begin
      do_reset();
      burst_code = c[2:0]; base0 = 0; ceil0 = 4;
      pulse_run();
      serve_frame(0, 4, 1, "R4 illegal code");
      drain("R4");
    end

    // R8 and R5 (no alternation): mid-frame reprogramming
    do_reset();
    dual_en = 0; burst_code = 3; base0 = 100; ceil0 = 131; base1 = 300; ceil1 = 310;
    @(negedge clk); run = 1;
    serve_bursts(100, 131, 8, 2, "R8 first half", an);
    base0 = 200; ceil0 = 209;
    serve_frame(an, 131, 8, "R8 old range kept");
    @(negedge clk);
    run = 0;
    chk(status[9:8] == 2'b01, "R5 R6 single-buffer eof", status[9:8], 1);
    clr_stat(10'h100);
    serve_frame(200, 209, 8, "R8 new range next frame");
    @(negedge clk);
    chk(status[9:8] == 2'b01, "R5 buffer 0 again", status[9:8], 1);
    drain("R8");

    // R5 R6 R7 R12: alternation, flags, clears, interrupt
    do_reset();
    dual_en = 1; burst_code = 2; base0 = 0; ceil0 = 11; base1 = 64; ceil1 = 69;
    irq_en = 10'h100;
    @(negedge clk); run = 1;
    serve_frame(0, 11, 4, "R5 frame buffer0");
    @(negedge clk);
    chk(status[9:8] == 2'b01, "R6 eof0 only", status[9:8], 1);
    @(negedge clk);
    chk(irq == 1, "R12 irq from enabled eof0", irq, 1);
    serve_frame(64, 69, 4, "R5 frame buffer1");
    @(negedge clk);
    chk(status[9:8] == 2'b11, "R6 eof1 set", status[9:8], 3);
    clr_stat(10'h100);
    chk(status == 10'h200, "R7 clear one flag only", status, 10'h200);
    @(negedge clk);
    chk(irq == 0, "R12 irq low for disabled eof1", irq, 0);
    clr_stat(10'h200);
    chk(status == 0, "R7 second clear", status, 0);
    run = 0;
    serve_frame(0, 11, 4, "R5 back to buffer0");
    @(negedge clk);
    chk(status[9:8] == 2'b01, "R6 eof0 third frame", status[9:8], 1);
    irq_en = 0;
    drain("R5");

    // R10: FIFO backpressure
    do_reset();
    dual_en = 0; burst_code = 4; base0 = 0; ceil0 = 63;
    drain_en = 0;
    pulse_run();
    serve_bursts(0, 63, 16, 2, "R10 fill", an);
    hits = 0;
    repeat (12) begin @(negedge clk); if (mem_req) hits++; end
    chk(hits == 0, "R10 no request while full", hits, 0);
    drain_en = 1;
    serve_frame(an, 63, 16, "R10 resume");
    drain("R10");

    // R11: empty pop
    drain_en = 0;
    irq_en = 10'h020;
    @(negedge clk); force_pop = 1;
    @(negedge clk); force_pop = 0;
    chk(status[5] == 1, "R11 underflow flag", status[5], 1);
    chk(pix_valid == 0, "R11 no data on empty pop", pix_valid, 0);
    @(negedge clk);
    chk(irq == 1, "R12 irq from underflow", irq, 1);
    irq_en = 0;
    drain_en = 1;

    // R9: palette-only
    do_reset();
    load_mode = 1; dual_en = 1; burst_code = 2; base0 = 40; ceil0 = 49; base1 = 300; ceil1 = 305;
    @(negedge clk); run = 1;
    serve_frame(40, 49, 4, "R9 palette fetch");
    @(negedge clk);
    chk(status == 10'h040, "R9 palette done only", status, 10'h040);
    hits = 0;
    repeat (20) begin @(negedge clk); if (mem_req) hits++; end
    chk(hits == 0, "R9 no fetch after palette", hits, 0);
    run = 0;
    repeat (2) @(negedge clk);
    load_mode = 2;
    pulse_run();
    serve_frame(40, 49, 4, "R9 R5 data starts at buffer0");
    drain("R9");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule